// File: doc/BRIEF.md
# Asynchronous SRAM Cycle Sequencer

This block sits between a clocked host and a static memory device that has no clock of its own. The host raises a request with a direction, an address and (for writes) a data word. The sequencer then runs one fixed bus cycle of four system-clock phases, T1 to T4. It drives the memory address, a memory enable and a single read/write line, which is high for a read and pulses low as the write strobe. It also drives the write data together with an output-enable that turns the data drivers on.

On a read, the word returned by the memory is registered on the clock edge that closes T4. On every access, a one-cycle completion pulse follows that edge. The write strobe falls at the start of T2 and rises at the start of T4. Address and write data are held for the whole T1 to T4 window, so the memory sees one full clock of address setup before the strobe falls. It also sees one full clock of address and data hold after the strobe rises. A request raised in the cycle that carries the completion pulse opens a new T1 on the next clock.

Top module: `sram_cycle_seq`

## Requirements
- R1: After reset, mem_en is 0, mem_rw_n is 1, mem_wdata_oe is 0, mem_wdata is 0, done is 0 and rdata is 0.
- R2: A request (req=1) sampled on a clock edge while idle starts T1 in the following cycle. mem_en is 1 for exactly the four cycles T1..T4, and mem_addr equals the request address.
- R3: In a read cycle (req_write=0), mem_rw_n stays 1 in all four phases. rdata takes the value on mem_rdata at the clock edge that ends T4.
- R4: In a write cycle (req_write=1), mem_rw_n is 1 in T1, 0 in T2 and T3, and 1 again in T4. The strobe never falls or rises while mem_en is 0.
- R5: mem_addr is held unchanged from T1 through T4. In a write cycle, mem_wdata equals the request data and mem_wdata_oe is 1 in all of T1..T4.
- R6: done is 1 for exactly one cycle, the cycle after T4 (the fifth cycle after the accepting edge). mem_en is 0 in that cycle.
- R7: req raised while a cycle is in progress (T1..T4) is ignored. It changes neither the address in use nor the cycle length, and no new cycle starts after done.
- R8: rdata holds its value through write cycles and idle time, and changes only when a read completes.
- R9: A request raised in the done cycle starts T1 on the next clock, with no idle cycle in between.
- R10: Outside write cycles, mem_wdata_oe is 0 and mem_wdata is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| req | input | 1 | Access request, sampled while idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Access address |
| req_wdata | input | DW | Data to write |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | DW | Last word read |
| mem_addr | output | AW | Memory address lines |
| mem_en | output | 1 | Memory enable, active high |
| mem_rw_n | output | 1 | 1 = read, pulsed 0 as write strobe |
| mem_wdata | output | DW | Write data toward the memory |
| mem_wdata_oe | output | 1 | Write data driver enable |
| mem_rdata | input | DW | Data returned by the memory |

## Verification
Completion of one access and acceptance of the next can fall in the same cycle. The done pulse and a new request meet on the edge that closes the done cycle. The bench provokes this by raising req, with a fresh address and direction, exactly in the cycle where done is high. It then judges the result by requiring mem_en and the new address to appear in the very next cycle. The bench also requires the previous read result to be present in rdata at the same point. Random chains of such back-to-back reads and writes run against a behavioural memory model. That model flags any strobe edge taken while the address moved or the data drivers were off.

// File: rtl/sram_seq_pkg.sv
package sram_seq_pkg;

    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_T1   = 3'd1,
        PH_T2   = 3'd2,
        PH_T3   = 3'd3,
        PH_T4   = 3'd4
    } phase_e;

    localparam int unsigned PHASES_PER_ACCESS = 4;

    function automatic phase_e phase_after(input phase_e p);
        case (p)
            PH_T1:   return PH_T2;
            PH_T2:   return PH_T3;
            PH_T3:   return PH_T4;
            default: return PH_IDLE;
        endcase
    endfunction

    function automatic logic strobe_window(input phase_e p);
        return (p == PH_T2) || (p == PH_T3);
    endfunction

    function automatic logic phase_busy(input phase_e p);
        return p != PH_IDLE;
    endfunction

endpackage

// File: rtl/seq_phase_ctrl.sv
module seq_phase_ctrl
    import sram_seq_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req,
    input  logic                 req_write,
    input  logic [AW-1:0]        req_addr,
    input  logic [DW-1:0]        req_wdata,
    output phase_e               phase,
    output logic                 op_write,
    output logic [AW-1:0]        op_addr,
    output logic [DW-1:0]        op_wdata
);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= PH_IDLE;
            op_write <= 1'b0;
            op_addr  <= '0;
            op_wdata <= '0;
        end else if (phase == PH_IDLE) begin
            if (req) begin
                phase    <= PH_T1;
                op_write <= req_write;
                op_addr  <= req_addr;
                op_wdata <= req_wdata;
            end
        end else begin
            phase <= phase_after(phase);
        end
    end

    // R7: the latched request stays fixed while a cycle runs
    assert_op_locked_R7: assert property (@(posedge clk) disable iff (rst)
        (phase_busy(phase) && phase != PH_T1) |-> ($stable(op_addr) && $stable(op_write)));

endmodule

// File: rtl/seq_bus_drive.sv
module seq_bus_drive
    import sram_seq_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  phase_e               phase,
    input  logic                 op_write,
    input  logic [AW-1:0]        op_addr,
    input  logic [DW-1:0]        op_wdata,
    output logic [AW-1:0]        mem_addr,
    output logic                 mem_en,
    output logic                 mem_rw_n,
    output logic [DW-1:0]        mem_wdata,
    output logic                 mem_wdata_oe
);

    logic busy;

    always_comb begin
        busy         = phase_busy(phase);
        mem_addr     = op_addr;
        mem_en       = busy;
        mem_rw_n     = !(busy && op_write && strobe_window(phase));
        mem_wdata_oe = busy && op_write;
        mem_wdata    = mem_wdata_oe ? op_wdata : '0;
    end

endmodule

// File: rtl/seq_read_capture.sv
module seq_read_capture
    import sram_seq_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  phase_e               phase,
    input  logic                 op_write,
    input  logic [DW-1:0]        mem_rdata,
    output logic [DW-1:0]        rdata,
    output logic                 done
);

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
            done  <= 1'b0;
        end else begin
            done <= (phase == PH_T4);
            if (phase == PH_T4 && !op_write) begin
                rdata <= mem_rdata;
            end
        end
    end

    // R8: rdata only moves together with a completion pulse
    assert_rdata_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !$stable(rdata) |-> done);

endmodule

// File: rtl/sram_cycle_seq.sv
module sram_cycle_seq
    import sram_seq_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req,
    input  logic                 req_write,
    input  logic [AW-1:0]        req_addr,
    input  logic [DW-1:0]        req_wdata,
    output logic                 done,
    output logic [DW-1:0]        rdata,
    output logic [AW-1:0]        mem_addr,
    output logic                 mem_en,
    output logic                 mem_rw_n,
    output logic [DW-1:0]        mem_wdata,
    output logic                 mem_wdata_oe,
    input  logic [DW-1:0]        mem_rdata
);

    phase_e            phase;
    logic              op_write;
    logic [AW-1:0]     op_addr;
    logic [DW-1:0]     op_wdata;

    seq_phase_ctrl #(.AW(AW), .DW(DW)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .req       (req),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .phase     (phase),
        .op_write  (op_write),
        .op_addr   (op_addr),
        .op_wdata  (op_wdata)
    );

    seq_bus_drive #(.AW(AW), .DW(DW)) u_drive (
        .phase        (phase),
        .op_write     (op_write),
        .op_addr      (op_addr),
        .op_wdata     (op_wdata),
        .mem_addr     (mem_addr),
        .mem_en       (mem_en),
        .mem_rw_n     (mem_rw_n),
        .mem_wdata    (mem_wdata),
        .mem_wdata_oe (mem_wdata_oe)
    );

    seq_read_capture #(.DW(DW)) u_capture (
        .clk       (clk),
        .rst       (rst),
        .phase     (phase),
        .op_write  (op_write),
        .mem_rdata (mem_rdata),
        .rdata     (rdata),
        .done      (done)
    );

    // R2: a cycle opens only after a request was seen
    assert_open_on_req_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_en) |-> $past(req));

    // R4: strobe low only inside an enabled write with data driven
    assert_strobe_inside_R4: assert property (@(posedge clk) disable iff (rst)
        !mem_rw_n |-> (mem_en && mem_wdata_oe));

    // R4: strobe falls only after a full clock of enabled address
    assert_strobe_setup_R4: assert property (@(posedge clk) disable iff (rst)
        $fell(mem_rw_n) |-> $past(mem_en));

    // R5: address fixed while the device is enabled
    assert_addr_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (mem_en && $past(mem_en)) |-> $stable(mem_addr));

    // R6: completion is one cycle wide and follows the enabled window
    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    assert_done_after_R6: assert property (@(posedge clk) disable iff (rst)
        done |-> ($past(mem_en) && !mem_en));

    // R10: data drivers off whenever the device is not enabled
    assert_drivers_off_R10: assert property (@(posedge clk) disable iff (rst)
        !mem_en |-> (!mem_wdata_oe && mem_wdata == '0));

endmodule

// File: tb/test_sram_cycle_seq.sv
module test_sram_cycle_seq;

    localparam int AW = 8;
    localparam int DW = 8;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req = 1'b0;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          done;
    logic [DW-1:0] rdata;
    logic [AW-1:0] mem_addr;
    logic          mem_en;
    logic          mem_rw_n;
    logic [DW-1:0] mem_wdata;
    logic          mem_wdata_oe;
    logic [DW-1:0] mem_rdata;

    int checks = 0;
    int fails  = 0;
    int model_bad = 0;
    int strobe_rises = 0;
    int writes_issued = 0;
    bit finished = 0;

    logic [DW-1:0] model_mem [DEPTH];
    logic [DW-1:0] shadow    [DEPTH];
    logic [DW-1:0] last_rd;
    logic [AW-1:0] fall_addr;

    always #4 clk = ~clk;

    sram_cycle_seq #(.AW(AW), .DW(DW)) i_sram_cycle_seq (
        .clk          (clk),
        .rst          (rst),
        .req          (req),
        .req_write    (req_write),
        .req_addr     (req_addr),
        .req_wdata    (req_wdata),
        .done         (done),
        .rdata        (rdata),
        .mem_addr     (mem_addr),
        .mem_en       (mem_en),
        .mem_rw_n     (mem_rw_n),
        .mem_wdata    (mem_wdata),
        .mem_wdata_oe (mem_wdata_oe),
        .mem_rdata    (mem_rdata)
    );

    // behavioural asynchronous memory
    assign mem_rdata = (mem_en === 1'b1 && mem_rw_n === 1'b1) ? model_mem[mem_addr] : '0;

    always @(negedge mem_rw_n) begin
        if (!rst) begin
            fall_addr = mem_addr;
            if (mem_en !== 1'b1) model_bad++;
        end
    end

    always @(posedge mem_rw_n) begin
        if (!rst && mem_en === 1'b1) begin
            strobe_rises++;
            if (mem_addr !== fall_addr || mem_wdata_oe !== 1'b1) model_bad++;
            model_mem[mem_addr] = mem_wdata;
        end
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic exp_rw_n(input bit w, input int ph);
        return !(w && (ph == 2 || ph == 3));
    endfunction

    // runs one access; pre=1 means req was already raised in the done cycle
    task automatic access(input bit w, input logic [AW-1:0] a, input logic [DW-1:0] d,
                          input bit pre, input bit ign);
        logic [DW-1:0] exp_r;
        if (!pre) begin
            @(negedge clk);
            req = 1'b1; req_write = w; req_addr = a; req_wdata = d;
        end
        exp_r = w ? last_rd : shadow[a];
        if (w) writes_issued++;
        for (int ph = 1; ph <= 4; ph++) begin
            @(negedge clk);
            if (ph == 1) req = 1'b0;
            check(mem_en === 1'b1, "R2 enable in cycle", mem_en, 1);
            check(mem_addr === a, "R5 address held", mem_addr, a);
            check(mem_rw_n === exp_rw_n(w, ph), w ? "R4 write strobe" : "R3 read line high",
                  mem_rw_n, exp_rw_n(w, ph));
            check(mem_wdata_oe === w, w ? "R5 drivers on" : "R10 drivers off", mem_wdata_oe, w);
            check(mem_wdata === (w ? d : '0), w ? "R5 write data" : "R10 data gated",
                  mem_wdata, w ? d : '0);
            check(done === 1'b0, "R6 no early done", done, 0);
            if (ign && ph == 2) begin
                req = 1'b1; req_write = ~w; req_addr = a ^ 8'h5A; req_wdata = ~d;
            end
            if (ign && ph == 3) req = 1'b0;
        end
        @(negedge clk);
        check(done === 1'b1, "R6 done after T4", done, 1);
        check(mem_en === 1'b0, "R6 enable off at done", mem_en, 0);
        check(mem_rw_n === 1'b1, "R4 strobe high at done", mem_rw_n, 1);
        check(rdata === exp_r, w ? "R8 rdata held over write" : "R3 read data", rdata, exp_r);
        if (w) shadow[a] = d;
        else last_rd = shadow[a];
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] seed;
        seed = $urandom(32'h0051A3C5);
        for (int i = 0; i < DEPTH; i++) begin
            model_mem[i] = DW'($urandom);
            shadow[i]    = model_mem[i];
        end
        last_rd = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(mem_en === 1'b0, "R1 reset enable", mem_en, 0);
        check(mem_rw_n === 1'b1, "R1 reset strobe", mem_rw_n, 1);
        check(mem_wdata_oe === 1'b0 && mem_wdata === '0, "R1 reset drivers", mem_wdata_oe, 0);
        check(done === 1'b0 && rdata === '0, "R1 reset outputs", {done, rdata}, 0);
        rst = 1'b0;

        // directed corners
        access(1'b0, 8'h00, 8'h00, 0, 0);
        access(1'b1, 8'hFF, 8'hA5, 0, 0);
        access(1'b0, 8'hFF, 8'h00, 0, 0);
        access(1'b1, 8'h10, 8'h3C, 0, 1);
        @(negedge clk);
        check(mem_en === 1'b0, "R7 busy request dropped", mem_en, 0);
        check(done === 1'b0, "R6 single pulse", done, 0);
        check(model_mem[8'h10 ^ 8'h5A] === shadow[8'h10 ^ 8'h5A], "R7 no stray write",
              model_mem[8'h10 ^ 8'h5A], shadow[8'h10 ^ 8'h5A]);
        access(1'b0, 8'h10, 8'h00, 0, 0);
        check(rdata === 8'h3C, "R3 read after write", rdata, 8'h3C);

        // back-to-back: write, then read in done cycle
        access(1'b1, 8'h22, 8'h81, 0, 0);
        req = 1'b1; req_write = 1'b0; req_addr = 8'h22; req_wdata = '0;
        access(1'b0, 8'h22, 8'h00, 1, 0);
        check(rdata === 8'h81, "R9 chained read data", rdata, 8'h81);

        // random mix, half chained back-to-back
        for (int n = 0; n < 300; n++) begin
            bit w;
            bit chain;
            logic [AW-1:0] a;
            logic [DW-1:0] d;
            w = 1'($urandom);
            chain = 1'($urandom) && (n > 0);
            a = AW'($urandom);
            d = DW'($urandom);
            if (chain) begin
                req = 1'b1; req_write = w; req_addr = a; req_wdata = d;
            end
            access(w, a, d, chain, (n % 17) == 5);
        end

        @(negedge clk);
        check(model_bad == 0, "R4 model strobe timing", model_bad, 0);
        check(strobe_rises == writes_issued, "R4 one strobe per write", strobe_rises, writes_issued);
        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule